// File: doc/BRIEF.md
# Power-Good Deglitch Filter

This block decides whether a regulator's power-good line is released or held low. Three comparator flags come in: the feedback voltage is over the upper (92.5 %) threshold, the feedback voltage is under the lower (90 %) threshold, and the reference voltage is high enough to be valid (over 0.54 V). Three fault flags also come in: shutdown, supply lockout and over-temperature. The output is an active-high pull-down enable that stands in for the open-drain transistor. A 1 pulls the line low and a 0 lets it float high.

A change of state needs a run of consecutive qualifying clocks. The run length is the parameter `RUN_LEN`, which defaults to 48. To release, the block needs the upper flag together with a valid reference. To pull low again, it needs the lower flag or an invalid reference. The gap between the two thresholds gives hysteresis. Any fault pulls the line low at the next clock edge and discards a partly counted run.

Top module: `pgood_filter`

## Requirements
- R1: While reset is asserted and after it is released, `pull_low_o` is 1.
- R2: In the pulled-low state, `pull_low_o` drops to 0 at the clock edge that samples the `RUN_LEN`-th (48th by default) consecutive cycle with `fb_over_hi_i`=1, `ref_valid_i`=1 and no fault. It stays 1 at the edge before that.
- R3: In the released state, `pull_low_o` returns to 1 at the edge that samples the `RUN_LEN`-th consecutive cycle with (`fb_under_lo_i`=1 or `ref_valid_i`=0) and no fault. It stays 0 before that.
- R4: Hysteresis: in either state, while both feedback flags are 0, `ref_valid_i`=1 and no fault is present, `pull_low_o` keeps its value indefinitely.
- R5: `ref_valid_i`=0 prevents release even when `fb_over_hi_i`=1. In the released state it counts as a pull-low condition even when `fb_under_lo_i`=0.
- R6: If any of `shutdown_i`, `uvlo_i` or `overtemp_i` is 1 at a clock edge, `pull_low_o` is 1 after that edge, whatever the feedback flags are.
- R7: A fault that lasts a single cycle during a partly counted release run discards that run, and the next release again needs a full `RUN_LEN` consecutive cycles.
- R8: A single non-qualifying cycle inside a run, in either direction, restarts the count, and a full new run of `RUN_LEN` cycles is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_over_hi_i | input | 1 | Feedback is above the upper (92.5 %) threshold |
| fb_under_lo_i | input | 1 | Feedback is below the lower (90 %) threshold |
| ref_valid_i | input | 1 | Reference is above its minimum valid level |
| shutdown_i | input | 1 | Regulator is disabled |
| uvlo_i | input | 1 | Internal supply is below its lockout level |
| overtemp_i | input | 1 | Thermal shutdown is active |
| pull_low_o | output | 1 | 1 = drive the open-drain power-good line low |

## Verification
The bench applies all 64 combinations of the six flags from both starting states. Each combination is held for exactly the run length, and the output is sampled after the first, the 47th and the 48th edge. An off-by-one counter would flip at 47 or at 49 cycles, and this grid catches either case. A design that left the reference out of either condition would flip wrongly in the rows where `ref_valid_i`=0. Directed runs break a run with one neutral cycle, and separately with one fault cycle, partway through. A counter that did not clear on either break would release early.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
   // Output state of the power-good filter; encoding equals the pull-down enable.
   typedef enum logic {
      PG_OPEN     = 1'b0,
      PG_HOLD_LOW = 1'b1
   } pg_state_e;

   function automatic logic pg_any_fault(input logic sd, input logic uv, input logic ot);
      return sd | uv | ot;
   endfunction
endpackage

// File: rtl/pgood_cond_sel.sv
module pgood_cond_sel
   import pgood_pkg::*;
(
   input  pg_state_e state_i,
   input  logic      fb_over_hi_i,
   input  logic      fb_under_lo_i,
   input  logic      ref_valid_i,
   output logic      qual_o
);
   logic rel_cond;
   logic ast_cond;

   // Release needs the upper threshold with a usable reference.
   assign rel_cond = fb_over_hi_i & ref_valid_i;
   // Pull-down needs the lower threshold or a lost reference.
   assign ast_cond = fb_under_lo_i | ~ref_valid_i;

   always_comb begin
      unique case (state_i)
         PG_HOLD_LOW: qual_o = rel_cond;
         PG_OPEN:     qual_o = ast_cond;
         default:     qual_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/pgood_run_counter.sv
module pgood_run_counter #(
   parameter int unsigned RUN_LEN = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic qual_i,
   output logic hit_o
);
   generate
      if (RUN_LEN == 1) begin : g_direct
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ clear_i;
         assign hit_o     = qual_i;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(RUN_LEN);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
         logic [CNT_W-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (clear_i || !qual_i)
               run_q <= '0;
            else
               run_q <= run_q + 1'b1;
         end

         assign hit_o = qual_i && (run_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pgood_filter.sv
module pgood_filter
   import pgood_pkg::*;
#(
   parameter int unsigned RUN_LEN = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fb_over_hi_i,
   input  logic fb_under_lo_i,
   input  logic ref_valid_i,
   input  logic shutdown_i,
   input  logic uvlo_i,
   input  logic overtemp_i,
   output logic pull_low_o
);
   generate
      if (RUN_LEN < 1) begin : g_bad_run_len
         $error("pgood_filter: RUN_LEN must be at least 1");
      end
   endgenerate

   pg_state_e state_q;
   logic      fault;
   logic      qual;
   logic      hit;
   logic      cnt_clear;

   assign fault     = pg_any_fault(shutdown_i, uvlo_i, overtemp_i);
   assign cnt_clear = fault | hit;

   pgood_cond_sel u_sel (
      .state_i      (state_q),
      .fb_over_hi_i (fb_over_hi_i),
      .fb_under_lo_i(fb_under_lo_i),
      .ref_valid_i  (ref_valid_i),
      .qual_o       (qual)
   );

   pgood_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(cnt_clear),
      .qual_i (qual),
      .hit_o  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= PG_HOLD_LOW;
      else if (fault)
         state_q <= PG_HOLD_LOW;
      else if (hit)
         state_q <= (state_q == PG_HOLD_LOW) ? PG_OPEN : PG_HOLD_LOW;
   end

   assign pull_low_o = (state_q == PG_HOLD_LOW);
endmodule

// File: rtl/pgood_filter_chk.sv
module pgood_filter_chk #(
   parameter int unsigned RUN_LEN = 48
) (
   input logic clk,
   input logic rst_n,
   input logic fb_over_hi_i,
   input logic fb_under_lo_i,
   input logic ref_valid_i,
   input logic shutdown_i,
   input logic uvlo_i,
   input logic overtemp_i,
   input logic pull_low_o
);
   localparam int unsigned RW = $clog2(RUN_LEN + 1);
   localparam logic [RW-1:0] SAT = RW'(RUN_LEN);

   logic          any_fault;
   logic          rel_ok;
   logic          ast_ok;
   logic [RW-1:0] rel_run;
   logic [RW-1:0] ast_run;

   assign any_fault = shutdown_i | uvlo_i | overtemp_i;
   assign rel_ok    = fb_over_hi_i & ref_valid_i & ~any_fault;
   assign ast_ok    = (fb_under_lo_i | ~ref_valid_i) & ~any_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_run <= '0;
         ast_run <= '0;
      end else begin
         rel_run <= !rel_ok ? '0 : ((rel_run == SAT) ? rel_run : rel_run + 1'b1);
         ast_run <= !ast_ok ? '0 : ((ast_run == SAT) ? ast_run : ast_run + 1'b1);
      end
   end

   // R2
   release_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_low_o) |-> (rel_run >= SAT));

   // R3
   assert_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pull_low_o) && !$past(any_fault)) |-> (ast_run >= SAT));

   // R4
   hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_over_hi_i && !fb_under_lo_i && ref_valid_i && !any_fault) |=> $stable(pull_low_o));

   // R6
   fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_fault |=> pull_low_o);
endmodule

bind pgood_filter pgood_filter_chk #(.RUN_LEN(RUN_LEN)) u_pgood_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fb_over_hi_i (fb_over_hi_i),
   .fb_under_lo_i(fb_under_lo_i),
   .ref_valid_i  (ref_valid_i),
   .shutdown_i   (shutdown_i),
   .uvlo_i       (uvlo_i),
   .overtemp_i   (overtemp_i),
   .pull_low_o   (pull_low_o)
);

// File: tb/test_pgood_filter.sv
`timescale 1ns/100ps
module test_pgood_filter;
   localparam int unsigned LEN = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hi = 1'b0, lo = 1'b0, rv = 1'b1, sd = 1'b0, uv = 1'b0, ot = 1'b0;
   logic pull_low;
   int   total = 0;
   int   bad = 0;

   always #2.5 clk = ~clk;

   pgood_filter #(.RUN_LEN(LEN)) i_pgood_filter (
      .clk(clk), .rst_n(rst_n),
      .fb_over_hi_i(hi), .fb_under_lo_i(lo), .ref_valid_i(rv),
      .shutdown_i(sd), .uvlo_i(uv), .overtemp_i(ot),
      .pull_low_o(pull_low)
   );

   task automatic check(input string tag, input logic exp);
      total++;
      if (pull_low !== exp) begin
         bad++;
         $display("FAIL %s: pull_low actual=%b expected=%b", tag, pull_low, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic h, input logic l, input logic r,
                        input logic s, input logic u, input logic o);
      hi = h; lo = l; rv = r; sd = s; uv = u; ot = o;
   endtask

   task automatic neutral();
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic go_pulled();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      step(1);
      neutral();
      step(1);
   endtask

   task automatic go_released();
      go_pulled();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step(LEN);
      neutral();
      step(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: held low in reset and right after release
      step(2);
      check("R1 in reset", 1'b1);
      step(2);
      rst_n = 1'b1;
      step(1);
      check("R1 after reset", 1'b1);
      step(5);
      check("R1 neutral hold", 1'b1);

      // Sweep of every flag combination from both states
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 64; v++) begin
            logic start_low, f, h, l, r, exp_end;
            string tag;
            start_low = (s == 0);
            h = v[0]; l = v[1]; r = v[2];
            f = v[3] | v[4] | v[5];
            if (start_low) go_pulled(); else go_released();
            check("R4 start state", start_low);
            drive(h, l, r, v[3], v[4], v[5]);
            if (f)                tag = "R6";
            else if (!r)          tag = "R5";
            else if (!h && !l)    tag = "R4";
            else if (start_low)   tag = "R2";
            else                  tag = "R3";
            step(1);
            check(tag, f ? 1'b1 : start_low);
            step(LEN - 2);
            check(tag, f ? 1'b1 : start_low);
            if (f)              exp_end = 1'b1;
            else if (start_low) exp_end = !(h & r);
            else                exp_end = l | !r;
            step(1);
            check(tag, exp_end);
            neutral();
         end
      end

      // R8: neutral break in a release run restarts it
      go_pulled();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step(40);
      neutral();
      step(1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step(LEN - 1);
      check("R8 release restart early", 1'b1);
      step(1);
      check("R8 release restart done", 1'b0);

      // R8: neutral break in a pull-low run restarts it
      go_released();
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(30);
      neutral();
      step(1);
      check("R8 break keeps open", 1'b0);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(LEN - 1);
      check("R8 assert restart early", 1'b0);
      step(1);
      check("R8 assert restart done", 1'b1);

      // R7: one-cycle fault discards a partial release run
      go_pulled();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step(30);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      step(1);
      check("R7 fault cycle", 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      step(LEN - 1);
      check("R7 run restarted early", 1'b1);
      step(1);
      check("R7 run restarted done", 1'b0);

      // R6: fault while released acts in one edge
      go_released();
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1);
      check("R6 lockout from open", 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule